// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides, for an in-order five-stage integer pipeline, where each operand of the instruction now in decode should come from when it reaches execute. It compares the two source register numbers of the decode instruction with the destinations of the two older instructions in execute and memory. From that comparison it produces a select code for each ALU operand. It also produces a separate flag that replaces store data with the memory/writeback result once the store reaches the memory stage. All outputs are combinational and are meant to be registered along with the decode instruction.

When the instruction in execute is a load and its result is needed as an ALU operand or as a memory base address, the value is not ready in time. The block then holds the program counter and the fetch/decode register for one cycle and asks for a bubble, with all write enables cleared, to be inserted into execute. A load whose result is only the data of the store right after it does not stall. That value is sent on into the memory stage instead. Results three instructions old need no path, because the register file writes before it reads in the same cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: The operand selects `fwd_a` (for `id_rs1`) and `fwd_b` (for `id_rs2`) use 2'b00 = register file, 2'b01 = execute/memory pipeline result, 2'b10 = memory/writeback result. With no matching older writer, the select is 2'b00, no stall is raised and `st_fwd_wb` is 0.
- R2: A non-load writer in execute whose destination equals a used source gives select 2'b01 for that operand, without a stall.
- R3: A load in execute whose destination equals a used source, other than the store-data operand of a store, raises `hold_front` and `bubble_ex` together in that same cycle. The two are always equal.
- R4: A load in execute whose destination is the base-address operand (`id_rs1`) of a following load or store raises the stall.
- R5: A load in execute whose destination is only the store-data operand of a store in decode raises no stall. It sets `st_fwd_wb` = 1 and gives that operand's select 2'b00. The store-data operand is `id_rs2` when `id_st_data_b` = 1 and `id_rs1` otherwise.
- R6: A writer in memory, whether load or not, whose destination equals a used source gives select 2'b10, without a stall, provided no writer in execute matches.
- R7: When writers in both execute and memory match the same source, the execute one wins. Select 2'b10 never appears for a source that the execute writer matches.
- R8: Register 0 is never a dependence, whether it is the source or the destination.
- R9: A source whose use flag is low is never a dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of decode instruction |
| id_rs2 | input | REG_AW | Second source register of decode instruction |
| id_use_a | input | 1 | Decode instruction reads `id_rs1` |
| id_use_b | input | 1 | Decode instruction reads `id_rs2` |
| id_is_store | input | 1 | Decode instruction is a store |
| id_st_data_b | input | 1 | Store data is `id_rs2` (1) or `id_rs1` (0) |
| ex_rd | input | REG_AW | Destination of instruction in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of instruction in memory |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| st_fwd_wb | output | 1 | Replace store data with writeback result in memory stage |
| hold_front | output | 1 | Hold PC and fetch/decode register |
| bubble_ex | output | 1 | Insert a no-write bubble into execute |

## Verification
The block holds no state, so a wrong internal decision shows up on the ports in the same cycle as the input pattern that triggers it. A bad priority or match term shows as a wrong select code. A bad load classification shows as a stall that should not be there, a missing stall, or a store-data flag in the wrong place. The bench compares every port against an independent model after each input change. It mixes random register numbers drawn from a narrow range, so that matches and register 0 come up often, with directed cases for the store-data and base-address distinction and for priority.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;

  // true when a writer with destination rd and enable wen produces src
  function automatic logic reg_hit(input logic [31:0] src, input logic [31:0] rd,
                                   input logic wen, input logic used);
    return used && wen && (src != 32'd0) && (src == rd);
  endfunction
endpackage

// File: rtl/fwd_operand.sv
module fwd_operand
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              used,
  input  logic              is_st_data,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  output fwd_sel_e          sel,
  output logic              stall_req,
  output logic              st_fwd
);
  localparam int PADW = 32 - REG_AW;

  logic ex_hit, mem_hit, ex_load_hit;

  assign ex_hit      = reg_hit({{PADW{1'b0}}, src}, {{PADW{1'b0}}, ex_rd}, ex_wen, used);
  assign mem_hit     = reg_hit({{PADW{1'b0}}, src}, {{PADW{1'b0}}, mem_rd}, mem_wen, used);
  assign ex_load_hit = ex_hit && ex_load;
  assign st_fwd      = ex_load_hit && is_st_data;
  assign stall_req   = ex_load_hit && !is_st_data;

  always_comb begin
    if (ex_hit && !ex_load)       sel = FWD_EXMEM;
    else if (mem_hit && !ex_hit)  sel = FWD_MEMWB;
    else                          sel = FWD_RF;
  end

  always_comb begin
    // R8
    zero_src_chk: assert (src != '0 || (sel == FWD_RF && !stall_req && !st_fwd))
      else $error("register 0 treated as dependence");
    // R9
    unused_src_chk: assert (used || (sel == FWD_RF && !stall_req && !st_fwd))
      else $error("unused source treated as dependence");
    // R7
    young_wins_chk: assert (!(sel == FWD_MEMWB && ex_hit))
      else $error("older result chosen over younger");
    // R5
    st_no_stall_chk: assert (!(st_fwd && stall_req))
      else $error("store-data forward also stalls");
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_a,
  input  logic              id_use_b,
  input  logic              id_is_store,
  input  logic              id_st_data_b,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              st_fwd_wb,
  output logic              hold_front,
  output logic              bubble_ex
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][REG_AW-1:0] srcs;
  logic [NOPS-1:0]             uses, st_data, stall_v, stfwd_v;
  fwd_sel_e                    sels [NOPS];

  assign srcs    = {id_rs2, id_rs1};
  assign uses    = {id_use_b, id_use_a};
  assign st_data = {id_is_store && id_st_data_b, id_is_store && !id_st_data_b};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_operand #(.REG_AW(REG_AW)) u_op (
      .src        (srcs[g]),
      .used       (uses[g]),
      .is_st_data (st_data[g]),
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_load    (ex_load),
      .mem_rd     (mem_rd),
      .mem_wen    (mem_wen),
      .sel        (sels[g]),
      .stall_req  (stall_v[g]),
      .st_fwd     (stfwd_v[g])
    );
  end

  logic load_use_stall;
  assign load_use_stall = |stall_v;

  assign fwd_a      = sels[0];
  assign fwd_b      = sels[1];
  assign st_fwd_wb  = |stfwd_v && !load_use_stall;
  assign hold_front = load_use_stall;
  assign bubble_ex  = load_use_stall;

  always_comb begin
    // R3
    bubble_pair_chk: assert (hold_front == bubble_ex)
      else $error("hold and bubble disagree");
    // R2
    alu_no_stall_chk: assert (ex_load || !hold_front)
      else $error("stall without a load in execute");
  end
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  localparam int AW = 5;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] rs1, rs2, exrd, memrd;
  logic usea, useb, isst, stb, exwen, exld, memwen;
  logic [1:0] fa, fb;
  logic stf, hold, bub;

  int checks = 0, errors = 0;

  hazard_fwd_unit #(.REG_AW(AW)) u_dut (
    .id_rs1(rs1), .id_rs2(rs2), .id_use_a(usea), .id_use_b(useb),
    .id_is_store(isst), .id_st_data_b(stb), .ex_rd(exrd), .ex_wen(exwen),
    .ex_load(exld), .mem_rd(memrd), .mem_wen(memwen),
    .fwd_a(fa), .fwd_b(fb), .st_fwd_wb(stf), .hold_front(hold), .bubble_ex(bub));

  // independent model: per operand outcome
  function automatic void model_op(input logic [AW-1:0] s, input logic u, input logic sd,
                                   output logic [1:0] sel, output logic stl, output logic sf);
    logic in_ex, in_mem;
    in_ex  = u && exwen && s != 0 && exrd == s;
    in_mem = u && memwen && s != 0 && memrd == s;
    sel = 2'b00; stl = 0; sf = 0;
    if (in_ex) begin
      if (!exld) sel = 2'b01;
      else if (sd) sf = 1;
      else stl = 1;
    end else if (in_mem) sel = 2'b10;
  endfunction

  task automatic check(input string tag);
    logic [1:0] ea, eb; logic sa, sb, xa, xb, est, esf;
    model_op(rs1, usea, isst && !stb, ea, sa, xa);
    model_op(rs2, useb, isst && stb, eb, sb, xb);
    est = sa | sb;
    esf = (xa | xb) && !est;
    checks++;
    if (fa !== ea || fb !== eb || hold !== est || bub !== est || stf !== esf) begin
      errors++;
      $display("FAIL %s: got fa=%b fb=%b hold=%b bub=%b st=%b exp fa=%b fb=%b stall=%b st=%b",
               tag, fa, fb, hold, bub, stf, ea, eb, est, esf);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic ua,
                       input logic ub, input logic st, input logic sdb,
                       input logic [AW-1:0] er, input logic ew, input logic el,
                       input logic [AW-1:0] mr, input logic mw);
    @(negedge clk);
    rs1 = a; rs2 = b; usea = ua; useb = ub; isst = st; stb = sdb;
    exrd = er; exwen = ew; exld = el; memrd = mr; memwen = mw;
    #1;
  endtask

  task automatic expect_ports(input string tag, input logic [1:0] ea, input logic [1:0] eb,
                              input logic es, input logic esf);
    checks++;
    if (fa !== ea || fb !== eb || hold !== es || bub !== es || stf !== esf) begin
      errors++;
      $display("FAIL %s: got fa=%b fb=%b hold=%b bub=%b st=%b exp fa=%b fb=%b stall=%b st=%b",
               tag, fa, fb, hold, bub, stf, ea, eb, es, esf);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // idle / reset state R1
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_ports("R1 idle", 2'b00, 2'b00, 0, 0);
    // R1 no match
    drive(3, 4, 1, 1, 0, 0, 5, 1, 0, 6, 1);
    expect_ports("R1 nomatch", 2'b00, 2'b00, 0, 0);
    // R2 ALU in EX to operand A and B
    drive(7, 9, 1, 1, 0, 0, 7, 1, 0, 0, 0);
    expect_ports("R2 alu A", 2'b01, 2'b00, 0, 0);
    drive(7, 9, 1, 1, 0, 0, 9, 1, 0, 0, 0);
    expect_ports("R2 alu B", 2'b00, 2'b01, 0, 0);
    // R3 load-use into ALU operand B
    drive(2, 8, 1, 1, 0, 0, 8, 1, 1, 0, 0);
    expect_ports("R3 loaduse", 2'b00, 2'b00, 1, 0);
    // R4 load feeding base of a store (rs1 base, rs2 data)
    drive(8, 3, 1, 1, 1, 1, 8, 1, 1, 0, 0);
    expect_ports("R4 base", 2'b00, 2'b00, 1, 0);
    // R4 load feeding base of a load
    drive(8, 0, 1, 0, 0, 0, 8, 1, 1, 0, 0);
    expect_ports("R4 loadbase", 2'b00, 2'b00, 1, 0);
    // R5 load feeding store data only
    drive(3, 8, 1, 1, 1, 1, 8, 1, 1, 0, 0);
    expect_ports("R5 stdata", 2'b00, 2'b00, 0, 1);
    // R5 with older MEM match on same register: data still from load
    drive(3, 8, 1, 1, 1, 1, 8, 1, 1, 8, 1);
    expect_ports("R5 stdata mem", 2'b00, 2'b00, 0, 1);
    // R5 store data on rs1 variant
    drive(8, 3, 1, 1, 1, 0, 8, 1, 1, 0, 0);
    expect_ports("R5 stdata rs1", 2'b00, 2'b00, 0, 1);
    // R4 + R5 same register as base and data: stall wins
    drive(8, 8, 1, 1, 1, 1, 8, 1, 1, 0, 0);
    expect_ports("R4 base and data", 2'b00, 2'b00, 1, 0);
    // R6 MEM producer, load and ALU
    drive(6, 4, 1, 1, 0, 0, 0, 0, 0, 6, 1);
    expect_ports("R6 mem A", 2'b10, 2'b00, 0, 0);
    drive(6, 4, 1, 1, 0, 0, 1, 1, 1, 4, 1);
    expect_ports("R6 mem B", 2'b00, 2'b10, 0, 0);
    // R7 both match, younger wins
    drive(5, 5, 1, 1, 0, 0, 5, 1, 0, 5, 1);
    expect_ports("R7 priority", 2'b01, 2'b01, 0, 0);
    // R8 register 0
    drive(0, 0, 1, 1, 0, 0, 0, 1, 1, 0, 1);
    expect_ports("R8 zero", 2'b00, 2'b00, 0, 0);
    // R9 unused source
    drive(4, 4, 0, 0, 0, 0, 4, 1, 1, 4, 1);
    expect_ports("R9 unused", 2'b00, 2'b00, 0, 0);
    // random mix against model
    for (int i = 0; i < 4000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1));
      check("R1 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule